// File: doc/BRIEF.md
# Segment Relocation and Protection Unit

This unit sits between a simple pipelined processor and its memory path. It turns logical addresses into physical ones using two independent segments: one for instruction fetch and one for loads and stores. Each segment has a base that is added to the logical address and a bound that limits how far into the segment an access may reach. The unit checks every request against the selected bound. A legal request leaves as a memory request with a relocated address. An illegal request is stopped and reported with a fault code that tells a fetch fault from a data fault.

The request path is combinational: the result appears in the same cycle as the request. The only state is the four configuration registers. Software programs them through a small register port that accepts writes and returns reads only while the processor is in supervisor mode. In supervisor mode requests bypass relocation and checking altogether.

Top module: `seg_xlate`

## Requirements
- R1: In user mode, a legal request produces `mem_valid`=1 and `mem_paddr` = logical address + selected base, taken modulo 2^32 (the carry out is dropped).
- R2: In user mode, a request is legal only when the logical address is strictly below the selected bound. A bound of zero makes every access fault.
- R3: `req_data`=0 marks an instruction fetch, which uses the program base and bound. `req_data`=1 marks a load/store, which uses the data base and bound.
- R4: On a violation, `mem_valid`=0, `mem_paddr`=0 and `fault_valid`=1. `fault_code` is 2'b01 for a fetch fault and 2'b10 for a data fault. With no fault, `fault_code` is 2'b00 and `mem_valid` and `fault_valid` are never high together.
- R5: With `req_valid`=0, all of `mem_valid`, `mem_paddr`, `fault_valid` and `fault_code` are zero.
- R6: In supervisor mode, a request passes through untranslated and unchecked: `mem_valid`=1, `mem_paddr` = logical address, and no fault.
- R7: A write with `sup_mode`=1 and `cfg_we`=1 takes effect at the next rising clock edge. The byte offsets are 0x0 program base, 0x4 program bound, 0x8 data base and 0xC data bound.
- R8: Writes with `sup_mode`=0 are ignored, and so are writes to any other address. `cfg_rdata` returns the addressed register in supervisor mode, and returns zero in user mode or for an unmapped address.
- R9: A synchronous active-high reset clears all four registers to zero, so every user-mode access faults until the registers are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | Processor is in supervisor mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 32 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| req_valid | input | 1 | Translation request present |
| req_data | input | 1 | 0 = instruction fetch, 1 = load/store |
| req_laddr | input | 32 | Logical address |
| mem_valid | output | 1 | Memory request issued |
| mem_paddr | output | 32 | Physical address, zero when no request is issued |
| fault_valid | output | 1 | Bounds violation |
| fault_code | output | 2 | 01 fetch fault, 10 data fault, 00 none |

## Verification
The bench sweeps logical addresses at 0, one below, at and one above each bound, plus spread values, for both request kinds and several register settings. An off-by-one comparison would accept the address equal to the bound, and swapped segment selection would relocate fetches with the data base. One setting places the data base near the top of the address space, so a sum that is not truncated to 32 bits, or one that saturates, shows up as a wrong address. Other checks cover a zero bound, user-mode writes and unmapped writes; a design that honoured any of those writes would return changed values on supervisor readback.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_FETCH = 2'b01,
    FLT_DATA  = 2'b10
  } fault_e;

  // segment index: 0 = program, 1 = data
  localparam int SEG_PROG = 0;
  localparam int SEG_DATA = 1;
  // register slot inside a segment
  localparam int SLOT_BASE  = 0;
  localparam int SLOT_BOUND = 1;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int AW   = 32,
  parameter int NSEG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic [AW-1:0] base_o  [NSEG],
  output logic [AW-1:0] bound_o [NSEG]
);
  localparam int NREG = 2 * NSEG;
  localparam int SELW = $clog2(NREG);

  logic [AW-1:0]   regs [NREG];
  logic [SELW-1:0] idx;
  logic            hit;

  assign idx = addr[SELW+1:2];
  assign hit = (addr[1:0] == 2'b00) && (addr[AW-1:SELW+2] == '0);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[r] <= '0;
      else if (sup && we && hit && idx == SELW'(r))
        regs[r] <= wdata;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign base_o[s]  = regs[2*s + seg_pkg::SLOT_BASE];
    assign bound_o[s] = regs[2*s + seg_pkg::SLOT_BOUND];
  end

  assign rdata = (sup && hit) ? regs[idx] : '0;
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] bound,
  output logic          ok,
  output logic [AW-1:0] paddr
);
  // bound is the segment length: last legal offset is bound-1
  assign ok    = laddr < bound;
  assign paddr = laddr + base;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup_mode,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          req_valid,
  input  logic          req_data,
  input  logic [AW-1:0] req_laddr,
  output logic          mem_valid,
  output logic [AW-1:0] mem_paddr,
  output logic          fault_valid,
  output logic [1:0]    fault_code
);
  import seg_pkg::*;

  localparam int NSEG = 2;

  logic [AW-1:0] seg_base  [NSEG];
  logic [AW-1:0] seg_bound [NSEG];
  logic [AW-1:0] seg_paddr [NSEG];
  logic          seg_ok    [NSEG];
  fault_e        code;

  seg_regfile #(.AW(AW), .NSEG(NSEG)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sup     (sup_mode),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .base_o  (seg_base),
    .bound_o (seg_bound)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    seg_check #(.AW(AW)) u_chk (
      .laddr (req_laddr),
      .base  (seg_base[s]),
      .bound (seg_bound[s]),
      .ok    (seg_ok[s]),
      .paddr (seg_paddr[s])
    );
  end

  always_comb begin
    mem_valid   = 1'b0;
    mem_paddr   = '0;
    fault_valid = 1'b0;
    code        = FLT_NONE;
    if (req_valid) begin
      if (sup_mode) begin
        mem_valid = 1'b1;
        mem_paddr = req_laddr;
      end else if (seg_ok[req_data]) begin
        mem_valid = 1'b1;
        mem_paddr = seg_paddr[req_data];
      end else begin
        fault_valid = 1'b1;
        code        = req_data ? FLT_DATA : FLT_FETCH;
      end
    end
  end

  assign fault_code = code;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          sup_mode,
  input logic          cfg_we,
  input logic          req_valid,
  input logic          req_data,
  input logic [AW-1:0] req_laddr,
  input logic          mem_valid,
  input logic [AW-1:0] mem_paddr,
  input logic          fault_valid,
  input logic [1:0]    fault_code,
  input logic [AW-1:0] pbase,
  input logic [AW-1:0] pbound,
  input logic [AW-1:0] dbase,
  input logic [AW-1:0] dbound
);
  // R6
  sup_pass_chk: assert property (@(posedge clk) disable iff (rst)
    sup_mode && req_valid |-> mem_valid && mem_paddr == req_laddr && !fault_valid);

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !fault_valid);

  // R4
  code_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> fault_code == (req_data ? 2'b10 : 2'b01));

  // R4
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> fault_code == 2'b00);

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !mem_valid && !fault_valid && mem_paddr == '0);

  // R2
  zero_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !sup_mode && req_valid &&
    ((req_data && dbound == '0) || (!req_data && pbound == '0)) |-> fault_valid);

  // R8
  user_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !sup_mode && cfg_we |=> $stable(pbase) && $stable(pbound) &&
                            $stable(dbase) && $stable(dbound));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_xlate_chk (
  .clk         (clk),
  .rst         (rst),
  .sup_mode    (sup_mode),
  .cfg_we      (cfg_we),
  .req_valid   (req_valid),
  .req_data    (req_data),
  .req_laddr   (req_laddr),
  .mem_valid   (mem_valid),
  .mem_paddr   (mem_paddr),
  .fault_valid (fault_valid),
  .fault_code  (fault_code),
  .pbase       (seg_base[0]),
  .pbound      (seg_bound[0]),
  .dbase       (seg_base[1]),
  .dbound      (seg_bound[1])
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sup_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_data = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        mem_valid;
  logic [31:0] mem_paddr;
  logic        fault_valid;
  logic [1:0]  fault_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [4];   // bench copy: pbase, pbound, dbase, dbound

  always #5 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_data(req_data), .req_laddr(req_laddr),
    .mem_valid(mem_valid), .mem_paddr(mem_paddr),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [35:0] model(logic sup, logic v, logic kind, logic [31:0] la);
    logic [31:0] base, bnd, pa;
    if (!v) return '0;
    if (sup) return {1'b1, la, 1'b0, 2'b00};
    base = kind ? m[2] : m[0];
    bnd  = kind ? m[3] : m[1];
    pa   = la + base;
    if (la < bnd) return {1'b1, pa, 1'b0, 2'b00};
    return {1'b0, 32'h0, 1'b1, kind ? 2'b10 : 2'b01};
  endfunction

  task automatic wr(logic sup, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    sup_mode = sup; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sup && a[1:0] == 2'b00 && a[31:4] == '0) m[a[3:2]] = d;
  endtask

  task automatic rd(logic sup, logic [31:0] a, logic [31:0] exp, string tag);
    sup_mode = sup; cfg_addr = a;
    #1;
    check(tag, {4'h0, cfg_rdata}, {4'h0, exp});
  endtask

  task automatic acc(logic sup, logic v, logic kind, logic [31:0] la, string tag);
    sup_mode = sup; req_valid = v; req_data = kind; req_laddr = la;
    #1;
    check(tag, {mem_valid, mem_paddr, fault_valid, fault_code}, model(sup, v, kind, la));
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: all registers cleared, user accesses fault
    for (int i = 0; i < 4; i++) rd(1'b1, 32'(i*4), 32'h0, "R9 reset value");
    acc(1'b0, 1'b1, 1'b0, 32'h0, "R9 R2 fetch faults after reset");
    acc(1'b0, 1'b1, 1'b1, 32'h0, "R9 R2 data faults after reset");

    for (int c = 0; c < 4; c++) begin
      logic [31:0] offs [10];
      wr(1'b1, 32'h0, 32'h1000_0000 * c + 32'h40);
      wr(1'b1, 32'h4, 32'h100 << c);
      wr(1'b1, 32'h8, 32'hFFFF_FF00 - 32'(c) * 32'h10);
      wr(1'b1, 32'hC, (c == 3) ? 32'h0 : 32'h180 + 32'(c));
      // R7: readback of each programmed register
      for (int i = 0; i < 4; i++) rd(1'b1, 32'(i*4), m[i], "R7 readback");
      for (int k = 0; k < 2; k++) begin
        logic [31:0] bnd;
        bnd = k ? m[3] : m[1];
        offs[0] = 32'h0; offs[1] = 32'h1; offs[2] = bnd - 32'h2;
        offs[3] = bnd - 32'h1; offs[4] = bnd; offs[5] = bnd + 32'h1;
        offs[6] = 32'hFFFF_FFFF; offs[7] = 32'h8000_0000;
        offs[8] = 32'hFF; offs[9] = 32'h100;
        // R1 R2 R3 R4 boundary sweep, user mode
        for (int j = 0; j < 10; j++)
          acc(1'b0, 1'b1, k[0], offs[j], "R1/R2/R3/R4 boundary");
        for (int j = 0; j < 32; j++)
          acc(1'b0, 1'b1, k[0], 32'(j) * 32'h0000_0013, "R1/R2/R3 spread");
        // R6: supervisor bypass
        for (int j = 0; j < 4; j++)
          acc(1'b1, 1'b1, k[0], offs[j+3], "R6 supervisor bypass");
        // R5: no request
        acc(1'b0, 1'b0, k[0], offs[2], "R5 idle user");
        acc(1'b1, 1'b0, k[0], offs[2], "R5 idle supervisor");
      end
    end

    // R1: wraparound of base + logical address
    wr(1'b1, 32'h8, 32'hFFFF_FFF0);
    wr(1'b1, 32'hC, 32'h40);
    acc(1'b0, 1'b1, 1'b1, 32'h20, "R1 wrap modulo 2^32");
    check("R1 wrap value", {4'h0, mem_paddr}, {4'h0, 32'h10});

    // R8: user-mode writes ignored
    for (int i = 0; i < 4; i++) wr(1'b0, 32'(i*4), 32'hDEAD_0000 + 32'(i));
    rd(1'b0, 32'h0, 32'h0, "R8 user read returns zero");
    acc(1'b0, 1'b1, 1'b1, 32'h3F, "R8 user write left data regs");
    acc(1'b0, 1'b1, 1'b0, 32'h10, "R8 user write left program regs");
    for (int i = 0; i < 4; i++) rd(1'b1, 32'(i*4), m[i], "R8 unchanged after user write");

    // R8: unmapped addresses ignored and read zero
    wr(1'b1, 32'h10, 32'h1234_5678);
    wr(1'b1, 32'h2, 32'h1234_5678);
    wr(1'b1, 32'h8000_0004, 32'h1234_5678);
    for (int i = 0; i < 4; i++) rd(1'b1, 32'(i*4), m[i], "R8 unchanged after unmapped write");
    rd(1'b1, 32'h10, 32'h0, "R8 unmapped read zero");
    rd(1'b1, 32'h6, 32'h0, "R8 misaligned read zero");

    // R9: reset again clears programmed registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) m[i] = '0;
    for (int i = 0; i < 4; i++) rd(1'b1, 32'(i*4), 32'h0, "R9 cleared by reset");

    finish_up();
  end
endmodule